// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps every row of a 512-row dynamic memory refreshed inside its retention window. A free-running interval timer produces one refresh credit per interval (by default 780 cycles of a 50 MHz clock, about 15.6 µs, so 512 credits fit into 8 ms). Credits collect in a pending counter. While credits are outstanding the block asks the memory access controller for the strobes with a request/grant handshake. If the controller holds off until the pending count reaches its ceiling, the block raises an urgent flag and takes the strobes on its own as soon as the bus is idle.

Once it has started, the block drives the row and column strobes through one complete refresh cycle in one of three styles, chosen by a mode input. The first style lowers the column strobe ahead of the row strobe, so the memory uses its own internal row counter. The second style pulses only the row strobe and puts a row address on the bus, taken from a 9-bit counter inside the block. The third style is a hidden refresh. It begins at the end of a read while the controller still holds the column strobe low. The block keeps that strobe low, precharges the row strobe and then pulses it again. The read data therefore stays on the bus. The data path is not part of this block.

Top module: `refr_sched`

## Requirements
- R1: During and right after reset, ras_n and cas_n are 1, busy, req and urgent are 0, and addr is 0.
- R2: The interval timer produces one credit every INTERVAL cycles. The first credit comes INTERVAL-1 cycles after reset is released. Each credit adds one to the pending count, and req is 1 whenever the block is idle with a nonzero pending count.
- R3: The pending count never goes above MAX_PEND. A credit that arrives at the ceiling is dropped. urgent is 1 exactly when the count equals MAX_PEND.
- R4: A refresh starts on the clock edge where the block is idle, the pending count is nonzero, and at least one of these holds: grant=1; urgent=1 with bus_idle=1; mode=2 with read_hold=1. The strobes change on that same edge.
- R5: A column-first refresh (mode 0, or mode 3) gives TCSR cycles with cas_n=0 and ras_n=1, then TRAS cycles with both strobes low, then TRP cycles with both high. addr stays 0 throughout.
- R6: A row-address refresh (mode 1) drives addr with the internal row for TCSR cycles with ras_n=1, then for TRAS cycles with ras_n=0, then gives TRP cycles of precharge. cas_n stays 1 for the whole cycle.
- R7: A hidden refresh (mode 2 with read_hold=1 at the start) gives TRP cycles with cas_n=0 and ras_n=1, then TRAS cycles with both strobes low, then TRP cycles with both high.
- R8: The internal row advances by one only when a row-address refresh completes, and it wraps from 511 to 0. Other refresh styles leave it unchanged.
- R9: Each completed refresh removes one credit. If a completion and a new credit fall on the same cycle, the count does not change.
- R10: busy is 1 from the first strobe cycle through the last precharge cycle, and it is 0 for at least one cycle between two refreshes. The mode and read_hold values are sampled only when a refresh starts; changes while busy have no effect.
- R11: In mode 2, a start caused by grant or by urgent while read_hold=0 performs a column-first refresh.
- R12: Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Controller hands the strobes to the scheduler |
| bus_idle | input | 1 | Controller has no access in progress |
| read_hold | input | 1 | A read is ending with the column strobe still low |
| mode | input | 2 | 0 column-first, 1 row-address, 2 hidden, 3 column-first |
| req | output | 1 | Refresh wanted (idle with credits pending) |
| urgent | output | 1 | Pending count at its ceiling |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr | output | ROW_W (9) | Row address during a row-address refresh, otherwise 0 |
| busy | output | 1 | Refresh cycle in progress |

## Verification
The hardest cases to reach are the ceiling of the pending counter and the forced start that follows from it. The stimulus gets there by withholding grant and bus_idle for several intervals, which drives the count to MAX_PEND so that credits are dropped. It then opens bus_idle with grant still low. Row wrap needs more than 512 completed row-address refreshes, so a long phase grants every request in mode 1 with a short interval. A final phase changes mode, grant and read_hold at random on every cycle, which covers mid-cycle mode changes and the hidden-mode fallback.

// File: rtl/refr_pkg.sv
package refr_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_ACT, PH_PRE} phase_e;
  typedef enum logic [1:0] {STY_CBR = 2'd0, STY_ROWADDR = 2'd1, STY_HIDDEN = 2'd2} style_e;
endpackage

// File: rtl/refr_interval.sv
module refr_interval #(
  parameter int INTERVAL = 780,
  parameter int MAX_PEND = 8,
  localparam int TW = $clog2(INTERVAL),
  localparam int PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  output logic          tick,
  output logic [PW-1:0] pend,
  output logic          urgent
);
  logic [TW-1:0] tcnt;

  assign tick   = (tcnt == '0);
  assign urgent = (pend == PW'(MAX_PEND));

  always_ff @(posedge clk) begin
    if (rst)       tcnt <= TW'(INTERVAL - 1);
    else if (tick) tcnt <= TW'(INTERVAL - 1);
    else           tcnt <= tcnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else begin
      case ({tick, done})
        2'b10:   if (!urgent) pend <= pend + 1'b1;
        2'b01:   if (pend != '0) pend <= pend - 1'b1;
        default: pend <= pend;
      endcase
    end
  end

  // R3: ceiling on outstanding credits
  p_pend_bound_r3: assert property (@(posedge clk) disable iff (rst)
    pend <= PW'(MAX_PEND));
  // R2: credits are spaced, never back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  // R9: a completion without a new credit removes exactly one
  p_drain_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !tick) |=> (pend == $past(pend) - 1'b1));
endmodule

// File: rtl/refr_row_ctr.sv
module refr_row_ctr #(
  parameter int ROWS = 512,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [RW-1:0] row
);
  always_ff @(posedge clk) begin
    if (rst)      row <= '0;
    else if (adv) row <= (row == RW'(ROWS - 1)) ? '0 : row + 1'b1;
  end

  // R8: step, wrap and hold of the row pointer
  p_row_step_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && row != RW'(ROWS - 1)) |=> (row == $past(row) + 1'b1));
  p_row_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (adv && row == RW'(ROWS - 1)) |=> (row == '0));
  p_row_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(row));
endmodule

// File: rtl/refr_seq.sv
module refr_seq
  import refr_pkg::*;
#(
  parameter int TRAS = 3,
  parameter int TRP  = 2,
  parameter int TCSR = 1,
  parameter int RW   = 9,
  localparam int TMAX = (TRAS > TRP) ? ((TRAS > TCSR) ? TRAS : TCSR)
                                     : ((TRP > TCSR) ? TRP : TCSR),
  localparam int CW = $clog2(TMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          read_hold,
  input  logic [RW-1:0] row,
  output logic          ras_n,
  output logic          cas_n,
  output logic [RW-1:0] addr,
  output logic          busy,
  output logic          done,
  output logic          adv
);
  phase_e  ph_q, ph_n;
  style_e  sty_q, sty_n, sel;
  logic [CW-1:0] left_q, left_n;
  logic strobe_n;

  always_comb begin
    if (mode == 2'd2)      sel = read_hold ? STY_HIDDEN : STY_CBR;
    else if (mode == 2'd1) sel = STY_ROWADDR;
    else                   sel = STY_CBR;
  end

  always_comb begin
    ph_n   = ph_q;
    sty_n  = sty_q;
    left_n = left_q;
    done   = 1'b0;
    case (ph_q)
      PH_IDLE: if (start) begin
        ph_n   = PH_LEAD;
        sty_n  = sel;
        left_n = (sel == STY_HIDDEN) ? CW'(TRP - 1) : CW'(TCSR - 1);
      end
      PH_LEAD: if (left_q == '0) begin
        ph_n = PH_ACT; left_n = CW'(TRAS - 1);
      end else left_n = left_q - 1'b1;
      PH_ACT: if (left_q == '0) begin
        ph_n = PH_PRE; left_n = CW'(TRP - 1);
      end else left_n = left_q - 1'b1;
      PH_PRE: if (left_q == '0) begin
        ph_n = PH_IDLE; done = 1'b1;
      end else left_n = left_q - 1'b1;
      default: ph_n = PH_IDLE;
    endcase
  end

  assign adv      = done && (sty_q == STY_ROWADDR);
  assign strobe_n = (ph_n == PH_LEAD) || (ph_n == PH_ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      sty_q  <= STY_CBR;
      left_q <= '0;
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
      addr   <= '0;
      busy   <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      sty_q  <= sty_n;
      left_q <= left_n;
      ras_n  <= (ph_n != PH_ACT);
      cas_n  <= !(strobe_n && sty_n != STY_ROWADDR);
      addr   <= (strobe_n && sty_n == STY_ROWADDR) ? row : '0;
      busy   <= (ph_n != PH_IDLE);
    end
  end

  // R5: column strobe already low when the row strobe falls
  p_cbr_cas_first_r5: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && sty_q == STY_CBR) |-> $past(!cas_n));
  // R6: row-address refresh never touches the column strobe
  p_rowaddr_cas_high_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && sty_q == STY_ROWADDR) |-> cas_n);
  p_addr_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (addr == '0));
  // R10: style frozen for the whole cycle
  p_style_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(sty_q));
endmodule

// File: rtl/refr_sched.sv
module refr_sched #(
  parameter int INTERVAL = 780,
  parameter int MAX_PEND = 8,
  parameter int TRAS     = 3,
  parameter int TRP      = 2,
  parameter int TCSR     = 1,
  parameter int ROWS     = 512,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int PW      = $clog2(MAX_PEND + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant,
  input  logic             bus_idle,
  input  logic             read_hold,
  input  logic [1:0]       mode,
  output logic             req,
  output logic             urgent,
  output logic             ras_n,
  output logic             cas_n,
  output logic [ROW_W-1:0] addr,
  output logic             busy
);
  logic [PW-1:0]    pend;
  logic [ROW_W-1:0] row;
  logic tick, done, adv, start;

  refr_interval #(.INTERVAL(INTERVAL), .MAX_PEND(MAX_PEND)) u_interval (
    .clk(clk), .rst(rst), .done(done), .tick(tick), .pend(pend), .urgent(urgent)
  );

  refr_row_ctr #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst(rst), .adv(adv), .row(row)
  );

  assign start = !busy && (pend != '0) &&
                 (grant || (urgent && bus_idle) || (mode == 2'd2 && read_hold));
  assign req   = !busy && (pend != '0);

  refr_seq #(.TRAS(TRAS), .TRP(TRP), .TCSR(TCSR), .RW(ROW_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .read_hold(read_hold),
    .row(row), .ras_n(ras_n), .cas_n(cas_n), .addr(addr), .busy(busy),
    .done(done), .adv(adv)
  );

  // R4: a refresh only begins with credit outstanding
  p_start_pending_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(pend) != '0));
endmodule

// File: tb/refr_sched_tb.sv
module refr_sched_tb;
  localparam int INTERVAL = 24;
  localparam int MAXP = 4;
  localparam int TRAS = 4;
  localparam int TRP = 3;
  localparam int TCSR = 2;
  localparam int ROWS = 512;

  logic clk = 0, rst = 1;
  logic grant = 0, bus_idle = 0, read_hold = 0;
  logic [1:0] mode = 0;
  logic req, urgent, ras_n, cas_n, busy;
  logic [8:0] addr;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  string ph_tag = "R1";

  // reference state
  int m_tcnt, m_pend, m_pos, m_sty, m_row, m_lead;
  bit m_active;

  always #10 clk = ~clk;

  refr_sched #(.INTERVAL(INTERVAL), .MAX_PEND(MAXP), .TRAS(TRAS), .TRP(TRP),
               .TCSR(TCSR), .ROWS(ROWS)) u_dut (
    .clk(clk), .rst(rst), .grant(grant), .bus_idle(bus_idle),
    .read_hold(read_hold), .mode(mode), .req(req), .urgent(urgent),
    .ras_n(ras_n), .cas_n(cas_n), .addr(addr), .busy(busy));

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_tcnt = INTERVAL - 1; m_pend = 0; m_pos = 0; m_sty = 0;
      m_row = 0; m_active = 0; m_lead = TCSR;
    end else begin
      bit tick, fin, go;
      tick = (m_tcnt == 0);
      fin  = m_active && (m_pos == m_lead + TRAS + TRP - 1);
      go   = !m_active && m_pend > 0 &&
             (grant || (m_pend == MAXP && bus_idle) || (mode == 2 && read_hold));
      if (fin) begin
        m_active = 0;
        if (m_sty == 1) m_row = (m_row + 1) % ROWS;
      end else if (m_active) m_pos++;
      else if (go) begin
        m_active = 1; m_pos = 0;
        m_sty = (mode == 1) ? 1 : ((mode == 2 && read_hold) ? 2 : 0);
        m_lead = (m_sty == 2) ? TRP : TCSR;
      end
      if (tick && !fin) m_pend = (m_pend < MAXP) ? m_pend + 1 : MAXP;
      else if (fin && !tick) m_pend--;
      m_tcnt = tick ? INTERVAL - 1 : m_tcnt - 1;
    end
  end

  task automatic chk(string rq, string sig, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s) %s act=%0d exp=%0d at cycle %0d", rq, ph_tag, sig, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit strobe;
      string st;
      strobe = m_active && m_pos < m_lead + TRAS;
      st = (m_sty == 0) ? "R5" : ((m_sty == 1) ? "R6" : "R7");
      chk(st, "ras_n", ras_n, !(m_active && m_pos >= m_lead && m_pos < m_lead + TRAS));
      chk(st, "cas_n", cas_n, !(strobe && m_sty != 1));
      chk("R8", "addr", addr, (strobe && m_sty == 1) ? m_row : 0);
      chk("R10", "busy", busy, m_active);
      chk("R9", "req", req, !m_active && m_pend > 0);
      chk("R3", "urgent", urgent, m_pend == MAXP);
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cycles(3);
    // R1: reset values while reset held
    chk("R1", "ras_n", ras_n, 1); chk("R1", "cas_n", cas_n, 1);
    chk("R1", "busy", busy, 0);   chk("R1", "req", req, 0);
    chk("R1", "urgent", urgent, 0); chk("R1", "addr", addr, 0);
    rst = 0;
    // R2 / R4: credits accumulate, no start without a trigger
    ph_tag = "R2"; cycles(3 * INTERVAL + 2);
    ph_tag = "R4"; grant = 1; cycles(6 * INTERVAL);
    // R3: starve until the ceiling, then forced start on idle bus
    ph_tag = "R3"; grant = 0; bus_idle = 0; cycles(7 * INTERVAL);
    bus_idle = 1; cycles(8 * INTERVAL);
    // R8: row-address refreshes past the wrap
    ph_tag = "R8"; mode = 1; grant = 1; cycles((ROWS + 20) * INTERVAL);
    // R7: hidden refreshes on read endings
    ph_tag = "R7"; mode = 2; grant = 0; bus_idle = 0;
    for (int i = 0; i < 40 * INTERVAL; i++) begin
      read_hold = ($urandom % 8) == 0; cycles(1);
    end
    read_hold = 0;
    // R11: hidden mode without a read ending falls back to column-first
    ph_tag = "R11"; grant = 1; cycles(10 * INTERVAL);
    // R12: mode 3 acts as column-first
    ph_tag = "R12"; mode = 3; cycles(10 * INTERVAL);
    // R10: everything changes at random, also mid-cycle
    ph_tag = "R10";
    for (int i = 0; i < 20000; i++) begin
      mode = 2'($urandom); grant = ($urandom % 4) == 0;
      bus_idle = $urandom % 2; read_hold = ($urandom % 5) == 0;
      cycles(1);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog (%s) act=running exp=finished", ph_tag);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule